// File: doc/BRIEF.md
# Timestamped Transmit Packet Scheduler

This block sits at the output of a transmit packet queue and decides when each queued packet may start feeding samples to the converter side. Every packet begins with two 32-bit words. The first is a header carrying a channel number and three control flags. The second is an absolute start time. The payload words follow, and the source marks the final word of a packet with a last flag. The scheduler keeps its own free-running sample-time counter. That counter advances once for each sample strobe from the converter side. The scheduler holds a packet until the counter reaches the packet's start time. From then on it releases one payload word per strobe.

A packet whose start time has already passed when it reaches the head of the queue is consumed and thrown away, and a sticky dropped flag is raised. A packet marked for immediate release, or one whose timestamp is all ones, starts on the next strobe whatever the time. The block also tracks whether a burst is open. A strobe that finds no sample ready inside an open burst raises a sticky underrun flag. Idle strobes between bursts raise nothing. Both flags are cleared by a one-cycle clear pulse.

Top module: `tx_ts_scheduler`

## Requirements
- R1: The header word is decoded as follows: bits 31:27 are the channel, bit 2 is the immediate flag, bit 1 opens a burst and bit 0 closes one. Every emitted sample carries the channel of its packet on `smp_chan`.
- R2: A packet is discarded with no samples emitted and no flag raised in three cases: a header with any of bits 26:3 set, a header word that carries `q_last`, or a timestamp word that carries `q_last`.
- R3: `sample_time` is 0 after reset. It increments by one, wrapping modulo 2^32, in each cycle where `sample_stb` is high, and otherwise holds its value.
- R4: For a timed packet, `q_ready` stays low while the packet waits. Its first payload word is consumed on the strobe at which `sample_time` equals the timestamp.
- R5: A timed packet is late when the timestamp minus `sample_time`, taken modulo 2^32, has bit 31 set. A late packet is consumed to its last word, emits no samples, and sets `drop_flag`.
- R6: A packet with the immediate flag set, or with timestamp 0xFFFFFFFF, releases its first payload word on the next strobe and is never judged late.
- R7: Once a packet has started, each strobe consumes one payload word. `smp_valid` pulses in the cycle after that strobe, with `smp_re` set to bits 31:16 and `smp_im` set to bits 15:0 of the word.
- R8: A burst opens when the first sample of a packet that has bit 1 set is consumed. It closes when the last sample of a packet that has bit 0 set is consumed. A strobe that consumes no sample while a burst is open sets `underrun_flag`. Dropped and malformed packets leave the burst state unchanged.
- R9: `drop_flag` and `underrun_flag` stay set until `flag_clr` is high for one cycle. If a new event occurs in the same cycle as the clear, the flag stays set.
- R10: During reset `q_ready` is 1 and `smp_valid`, `drop_flag`, `underrun_flag` and `sample_time` are 0.
- R11: Because lateness is judged by the sign of the difference, a timestamp 2^31+16 ahead of the counter counts as late. A timestamp 2^31-256 ahead is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_data | input | 32 | Word at the head of the queue |
| q_valid | input | 1 | Head word is present |
| q_last | input | 1 | Head word is the last word of its packet |
| q_ready | output | 1 | Head word is consumed this cycle when q_valid is high |
| sample_stb | input | 1 | Converter-side sample strobe |
| flag_clr | input | 1 | One-cycle clear of the sticky flags |
| sample_time | output | 32 | Current sample-time counter |
| smp_valid | output | 1 | A sample is presented this cycle |
| smp_re | output | 16 | Real part of the sample |
| smp_im | output | 16 | Imaginary part of the sample |
| smp_chan | output | 5 | Channel of the sample's packet |
| drop_flag | output | 1 | Sticky: a late packet was discarded |
| underrun_flag | output | 1 | Sticky: a strobe went unserved inside a burst |

## Verification
The bench sends a timed packet with the strobe running every cycle and checks that its first sample is taken exactly at the timestamp. A comparison off by one would show the sample one tick early or late. It sends a past timestamp and a timestamp just beyond half the counter range. A design that compared without sign would hold these forever instead of dropping them. It sends malformed headers, which must disappear without raising the dropped flag, and a burst that runs dry, which must raise underrun. After the burst is closed, idle strobes must not raise underrun again. A design that ignored burst framing, or that let dropped packets change it, would fail here.

// File: rtl/tx_sched_pkg.sv
// Shared constants and types for the timestamped transmit scheduler.
// Assumes a 32-bit word whose top bits hold the channel and whose low
// three bits hold the flags; everything in between must be zero.
package tx_sched_pkg;
    localparam int CHAN_W = 5;
    localparam int FLAG_W = 3;
    localparam int IMM_BIT = 2;
    localparam int SOB_BIT = 1;
    localparam int EOB_BIT = 0;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_TS   = 2'd1,
        ST_ARM  = 2'd2,
        ST_DISC = 2'd3
    } sched_state_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              imm;
        logic              sob;
        logic              eob;
        logic              bad;
    } hdr_info_t;
endpackage

// File: rtl/tx_hdr_decode.sv
// Header field decoder: splits a header word into channel, flags and a
// malformed indication (any must-be-zero bit set). Purely combinational.
module tx_hdr_decode
    import tx_sched_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    output hdr_info_t         info
);
    localparam int MBZ_HI = WORD_W - CHAN_W - 1;

    // Field extraction and must-be-zero check.
    always_comb begin
        info.chan = word[WORD_W-1 -: CHAN_W];
        info.imm  = word[IMM_BIT];
        info.sob  = word[SOB_BIT];
        info.eob  = word[EOB_BIT];
        info.bad  = |word[MBZ_HI:FLAG_W];
    end
endmodule

// File: rtl/tx_time_base.sv
// Sample-time counter and timestamp comparator. Counts sample strobes,
// and judges a timestamp as due (equal), late (negative difference, so it
// survives wraparound) or the all-ones "now" code.
// Assumes ts is stable while it is being judged.
module tx_time_base #(
    parameter int TIME_W      = 32,
    parameter bit NOW_CODE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [TIME_W-1:0] ts,
    output logic [TIME_W-1:0] now,
    output logic              due,
    output logic              late,
    output logic              now_code
);
    logic [TIME_W-1:0] now_q;
    logic [TIME_W-1:0] diff;

    // Free-running counter advanced by each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else if (stb) now_q <= now_q + 1'b1;
    end

    assign now  = now_q;
    assign diff = ts - now_q;
    assign due  = (diff == '0);
    assign late = diff[TIME_W-1];

    generate
        if (NOW_CODE_EN) begin : g_now_code
            assign now_code = &ts;
        end else begin : g_no_now_code
            assign now_code = 1'b0;
        end
    endgenerate

    // R3
    tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> now_q == TIME_W'($past(now_q) + 1'b1));
    // R3
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(now_q));
endmodule

// File: rtl/tx_burst_tracker.sv
// Burst framing tracker and sticky underrun flag. A burst opens on the
// first sample of a start-flagged packet and closes on the last sample of
// an end-flagged packet; unserved strobes inside a burst are underruns.
// Assumes emit is only high together with stb.
module tx_burst_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic emit,
    input  logic first,
    input  logic last,
    input  logic sob,
    input  logic eob,
    input  logic clr,
    output logic in_burst,
    output logic urun_flag
);
    logic burst_q;
    logic urun_q;
    logic urun_evt;

    assign urun_evt = stb && !emit && burst_q;

    // Burst open/close bookkeeping on emitted samples; close wins.
    always_ff @(posedge clk) begin
        if (!rst_n) burst_q <= 1'b0;
        else if (emit) begin
            if (last && eob) burst_q <= 1'b0;
            else if (first && sob) burst_q <= 1'b1;
        end
    end

    // Sticky underrun flag; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) urun_q <= 1'b0;
        else if (urun_evt) urun_q <= 1'b1;
        else if (clr) urun_q <= 1'b0;
    end

    assign in_burst  = burst_q;
    assign urun_flag = urun_q;

    // R8
    quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_q && !urun_q) |=> !urun_q);
    // R9
    urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urun_q && !clr) |=> urun_q);
endmodule

// File: rtl/tx_ts_scheduler.sv
// Timestamped transmit scheduler (top). Parses header and timestamp from
// the queue head, then holds, releases or drops the packet against the
// sample-time counter and streams one payload word per sample strobe.
// Assumes every well-formed packet has at least one payload word and
// that TIME_W equals WORD_W.
module tx_ts_scheduler
    import tx_sched_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int TIME_W      = 32,
    parameter int SAMP_W      = WORD_W / 2,
    parameter bit NOW_CODE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] q_data,
    input  logic              q_valid,
    input  logic              q_last,
    output logic              q_ready,
    input  logic              sample_stb,
    input  logic              flag_clr,
    output logic [TIME_W-1:0] sample_time,
    output logic              smp_valid,
    output logic [SAMP_W-1:0] smp_re,
    output logic [SAMP_W-1:0] smp_im,
    output logic [CHAN_W-1:0] smp_chan,
    output logic              drop_flag,
    output logic              underrun_flag
);
    sched_state_e      state_q, state_d;
    hdr_info_t         hdr_now, hdr_q;
    logic [TIME_W-1:0] ts_q;
    logic              started_q;
    logic              due, late, now_code;
    logic              go, arm_late, pop, emit;
    logic              drop_q;
    logic              in_burst;

    tx_hdr_decode #(.WORD_W(WORD_W)) u_hdr (
        .word (q_data),
        .info (hdr_now)
    );

    tx_time_base #(.TIME_W(TIME_W), .NOW_CODE_EN(NOW_CODE_EN)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (sample_stb),
        .ts       (ts_q),
        .now      (sample_time),
        .due      (due),
        .late     (late),
        .now_code (now_code)
    );

    tx_burst_tracker u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (sample_stb),
        .emit      (emit),
        .first     (!started_q),
        .last      (q_last),
        .sob       (hdr_q.sob),
        .eob       (hdr_q.eob),
        .clr       (flag_clr),
        .in_burst  (in_burst),
        .urun_flag (underrun_flag)
    );

    // Release and lateness decisions for the armed packet.
    always_comb begin
        go       = started_q || hdr_q.imm || now_code || due;
        arm_late = !started_q && !hdr_q.imm && !now_code && late;
    end

    // Queue pop enable per state.
    always_comb begin
        case (state_q)
            ST_ARM:  q_ready = sample_stb && go;
            default: q_ready = 1'b1;
        endcase
        pop  = q_ready && q_valid;
        emit = (state_q == ST_ARM) && pop;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_HDR: if (pop) begin
                if (q_last) state_d = ST_HDR;
                else if (hdr_now.bad) state_d = ST_DISC;
                else state_d = ST_TS;
            end
            ST_TS: if (pop) state_d = q_last ? ST_HDR : ST_ARM;
            ST_ARM: begin
                if (arm_late) state_d = ST_DISC;
                else if (emit && q_last) state_d = ST_HDR;
            end
            ST_DISC: if (pop && q_last) state_d = ST_HDR;
            default: state_d = ST_HDR;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HDR;
        else state_q <= state_d;
    end

    // Header and timestamp capture, plus started marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q     <= '0;
            ts_q      <= '0;
            started_q <= 1'b0;
        end else begin
            if (state_q == ST_HDR && pop && !hdr_now.bad && !q_last) hdr_q <= hdr_now;
            if (state_q == ST_TS && pop) begin
                ts_q      <= TIME_W'(q_data);
                started_q <= 1'b0;
            end
            if (emit) started_q <= 1'b1;
        end
    end

    // Sticky dropped-packet flag; a new drop beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= 1'b0;
        else if (state_q == ST_ARM && arm_late) drop_q <= 1'b1;
        else if (flag_clr) drop_q <= 1'b0;
    end
    assign drop_flag = drop_q;

    // Registered sample output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_re    <= '0;
            smp_im    <= '0;
            smp_chan  <= '0;
        end else begin
            smp_valid <= emit;
            if (emit) begin
                smp_re   <= q_data[WORD_W-1 -: SAMP_W];
                smp_im   <= q_data[SAMP_W-1:0];
                smp_chan <= hdr_q.chan;
            end
        end
    end

    // R7
    strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(sample_stb));
    // R4
    first_on_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !started_q && !hdr_q.imm && !now_code) |-> (sample_time == ts_q));
    // R5
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q && !flag_clr) |=> drop_q);
    // R2
    bad_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && q_valid && hdr_now.bad) |=> state_q != ST_TS);
    // R8
    burst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_burst && !emit) |=> !in_burst);
endmodule

// File: tb/tx_ts_scheduler_tb_top.sv
module tx_ts_scheduler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] q_data = '0;
    logic        q_valid = 1'b0, q_last = 1'b0, sample_stb = 1'b0, flag_clr = 1'b0;
    logic        q_ready, smp_valid, drop_flag, underrun_flag;
    logic [31:0] sample_time;
    logic [15:0] smp_re, smp_im;
    logic [4:0]  smp_chan;

    always #10 clk = ~clk;

    tx_ts_scheduler dut_i (
        .clk(clk), .rst_n(rst_n), .q_data(q_data), .q_valid(q_valid), .q_last(q_last),
        .q_ready(q_ready), .sample_stb(sample_stb), .flag_clr(flag_clr),
        .sample_time(sample_time), .smp_valid(smp_valid), .smp_re(smp_re),
        .smp_im(smp_im), .smp_chan(smp_chan), .drop_flag(drop_flag),
        .underrun_flag(underrun_flag)
    );

    int vectors = 0, miscompares = 0;
    typedef struct { logic [31:0] d; logic l; } wd_t;
    typedef struct { logic [31:0] t; logic [15:0] re, im; logic [4:0] ch; } emit_t;
    wd_t   src_q[$];
    emit_t log_q[$];
    int    stb_div = 3;
    int    cyc = 0;
    bit    clr_req = 0;
    bit    finished = 0;

    // behavioural reference model state
    int          ms = 0;
    logic [31:0] m_now = 0, m_ts = 0, m_diff;
    logic [4:0]  m_chan = 0, m_out_ch = 0;
    logic        m_imm = 0, m_s = 0, m_e = 0, m_started = 0, m_burst = 0;
    logic        m_drop = 0, m_urun = 0, m_sv = 0;
    logic [15:0] m_re = 0, m_im = 0;
    logic        m_go, m_late, m_ready, m_pop, m_emit;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Drive inputs, compare outputs, evaluate model combinational terms.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 smp_valid", {31'b0, smp_valid}, {31'b0, m_sv});
            if (m_sv) begin
                chk("R7 smp_re", {16'b0, smp_re}, {16'b0, m_re});
                chk("R7 smp_im", {16'b0, smp_im}, {16'b0, m_im});
                chk("R1 smp_chan", {27'b0, smp_chan}, {27'b0, m_out_ch});
            end
            chk("R3 sample_time", sample_time, m_now);
            chk("R5 drop_flag", {31'b0, drop_flag}, {31'b0, m_drop});
            chk("R8 underrun_flag", {31'b0, underrun_flag}, {31'b0, m_urun});
            if (smp_valid) log_q.push_back('{t: sample_time - 1, re: smp_re, im: smp_im, ch: smp_chan});
        end
        cyc++;
        sample_stb = (stb_div > 0) && (cyc % stb_div == 0);
        flag_clr   = clr_req;
        clr_req    = 0;
        q_valid    = src_q.size() > 0;
        q_data     = q_valid ? src_q[0].d : 32'h0;
        q_last     = q_valid ? src_q[0].l : 1'b0;
        #1;
        m_diff  = m_ts - m_now;
        m_go    = m_started || m_imm || (m_ts == 32'hFFFF_FFFF) || (m_diff == 0);
        m_late  = !m_started && !m_imm && (m_ts != 32'hFFFF_FFFF) && m_diff[31];
        m_ready = (ms == 2) ? (sample_stb && m_go) : 1'b1;
        m_pop   = m_ready && q_valid;
        m_emit  = (ms == 2) && m_pop;
        if (rst_n) chk("R4 q_ready", {31'b0, q_ready}, {31'b0, m_ready});
    end

    // Advance the reference model at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; m_now = 0; m_ts = 0; m_chan = 0; m_imm = 0; m_s = 0; m_e = 0;
            m_started = 0; m_burst = 0; m_drop = 0; m_urun = 0; m_sv = 0;
            m_re = 0; m_im = 0; m_out_ch = 0;
        end else begin
            if (ms == 2 && m_late) m_drop = 1; else if (flag_clr) m_drop = 0;
            if (sample_stb && !m_emit && m_burst) m_urun = 1; else if (flag_clr) m_urun = 0;
            if (m_emit) begin
                if (q_last && m_e) m_burst = 0;
                else if (!m_started && m_s) m_burst = 1;
            end
            m_sv = m_emit;
            if (m_emit) begin m_re = q_data[31:16]; m_im = q_data[15:0]; m_out_ch = m_chan; end
            case (ms)
                0: if (m_pop) begin
                    if (q_last) ms = 0;
                    else if (q_data[26:3] != 0) ms = 3;
                    else begin
                        m_chan = q_data[31:27]; m_imm = q_data[2];
                        m_s = q_data[1]; m_e = q_data[0]; ms = 1;
                    end
                end
                1: if (m_pop) begin m_ts = q_data; m_started = 0; ms = q_last ? 0 : 2; end
                2: if (m_late) ms = 3;
                   else if (m_emit) begin m_started = 1; if (q_last) ms = 0; end
                default: if (m_pop && q_last) ms = 0;
            endcase
            if (sample_stb) m_now = m_now + 1;
            if (m_pop) void'(src_q.pop_front());
        end
    end

    task automatic send_pkt(input logic [4:0] ch, input bit i, input bit s, input bit e,
                            input logic [31:0] ts, input int n, input logic [31:0] base);
        src_q.push_back('{d: {ch, 24'b0, i, s, e}, l: 1'b0});
        src_q.push_back('{d: ts, l: 1'b0});
        for (int k = 0; k < n; k++) src_q.push_back('{d: base + k, l: (k == n - 1)});
    endtask

    task automatic drain(input int extra);
        int guard = 0;
        while (src_q.size() > 0 && guard < 5000) begin @(negedge clk); guard++; end
        repeat (extra) @(negedge clk);
        #3;
    endtask

    task automatic pulse_clr();
        clr_req = 1;
        repeat (2) @(negedge clk);
        #3;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stimulus
        int n0;
        logic [31:0] ts_v;
        repeat (3) @(posedge clk);
        @(negedge clk); #3;
        // R10 reset state
        chk("R10 q_ready in reset", {31'b0, q_ready}, 32'd1);
        chk("R10 smp_valid in reset", {31'b0, smp_valid}, 32'd0);
        chk("R10 flags in reset", {30'b0, drop_flag, underrun_flag}, 32'd0);
        chk("R10 sample_time in reset", sample_time, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6 immediate flag ignores a far-future timestamp; R1 channel; R7 data
        stb_div = 3;
        send_pkt(5'd3, 1, 0, 0, m_now + 32'h0100_0000, 3, 32'h1111_0000);
        drain(12);
        chk("R6 immediate sample count", log_q.size(), 3);
        if (log_q.size() > 0) begin
            chk("R1 channel of sample", {27'b0, log_q[0].ch}, 32'd3);
            chk("R7 first real part", {16'b0, log_q[0].re}, 32'h1111);
            chk("R7 third imag part", {16'b0, log_q[2].im}, 32'h0002);
        end

        // R4 exact release at timestamp, strobe every cycle
        stb_div = 1;
        ts_v = m_now + 40;
        n0 = log_q.size();
        send_pkt(5'd7, 0, 0, 0, ts_v, 2, 32'hABCD_0010);
        drain(10);
        chk("R4 timed sample count", log_q.size() - n0, 2);
        if (log_q.size() > n0) chk("R4 first sample time", log_q[n0].t, ts_v);

        // R6 all-ones timestamp means now
        stb_div = 4;
        n0 = log_q.size();
        send_pkt(5'd9, 0, 0, 0, 32'hFFFF_FFFF, 2, 32'h2222_0000);
        drain(15);
        chk("R6 now-code sample count", log_q.size() - n0, 2);

        // R5 past timestamp is dropped
        n0 = log_q.size();
        send_pkt(5'd4, 0, 0, 0, m_now - 3, 3, 32'h3333_0000);
        drain(6);
        chk("R5 late packet emits nothing", log_q.size() - n0, 0);
        chk("R5 drop flag set", {31'b0, drop_flag}, 32'd1);

        // R9 clear
        pulse_clr();
        chk("R9 drop flag cleared", {31'b0, drop_flag}, 32'd0);

        // R2 malformed headers, silently discarded
        n0 = log_q.size();
        src_q.push_back('{d: 32'h1800_0400, l: 1'b0});
        src_q.push_back('{d: 32'h0000_0000, l: 1'b0});
        src_q.push_back('{d: 32'h4444_0000, l: 1'b1});
        src_q.push_back('{d: 32'h0800_0004, l: 1'b1});
        src_q.push_back('{d: 32'h0800_0004, l: 1'b0});
        src_q.push_back('{d: 32'h0000_0000, l: 1'b1});
        drain(6);
        chk("R2 malformed emits nothing", log_q.size() - n0, 0);
        chk("R2 malformed raises no drop", {31'b0, drop_flag}, 32'd0);
        chk("R2 queue consumed", src_q.size(), 0);

        // R8 underrun only inside a burst
        stb_div = 2;
        chk("R8 no underrun outside burst", {31'b0, underrun_flag}, 32'd0);
        send_pkt(5'd1, 1, 1, 0, 32'h0, 2, 32'h5555_0000);
        drain(12);
        chk("R8 underrun inside open burst", {31'b0, underrun_flag}, 32'd1);
        send_pkt(5'd1, 1, 0, 1, 32'h0, 1, 32'h6666_0000);
        drain(8);
        pulse_clr();
        repeat (12) @(negedge clk); #3;
        chk("R8 closed burst stays quiet", {31'b0, underrun_flag}, 32'd0);
        chk("R9 underrun flag cleared", {31'b0, underrun_flag}, 32'd0);

        // R11 sign-based lateness across half range
        stb_div = 3;
        send_pkt(5'd2, 0, 0, 0, m_now + 32'h8000_0010, 2, 32'h7777_0000);
        drain(6);
        chk("R11 half-range-ahead is late", {31'b0, drop_flag}, 32'd1);
        n0 = log_q.size();
        send_pkt(5'd2, 0, 0, 0, m_now + 32'h7FFF_FF00, 2, 32'h8888_0000);
        repeat (60) @(negedge clk); #3;
        chk("R11 just-under-half is held", {31'b0, q_ready}, 32'd0);
        chk("R11 held packet emits nothing", log_q.size() - n0, 0);
        chk("R11 payload still queued", src_q.size(), 2);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule